// File: doc/BRIEF.md
# Monochrome VGA Framebuffer Scanout Engine

This block produces a 640x480 raster for a VGA monitor from a single system clock. It divides the clock into a pixel-rate enable. On each enable it steps a horizontal and a vertical position, and it drives active-low horizontal and vertical sync, a video-enable flag and a one-bit black/white pixel. All of these outputs are registered. Pixels come from an external single-port SRAM that holds 16 pixels per 16-bit word. The block reads words with a one-clock read strobe and a 15-bit word address, holds one word in a prefetch buffer, and shifts the pixels out of a shift register starting with the most significant bit.

Two further outputs support a double-buffered frame store built outside the block. The bank-select bit flips at each vertical sync start. A positive-polarity copy of vertical sync lets an external processor follow the bank swaps. Both sequencers are built from the same four-state phase machine, with states ACTIVE, FRONT, SYNC and BACK. Each state moves to the next when its position counter reaches the last period of its region, and BACK returns to ACTIVE at the end of the line or frame. A three-state fetch machine runs IDLE to REQ when a fetch is due, REQ to CAPT after the one-clock read strobe, and CAPT to IDLE once the returned word is latched.

The geometry, the clock divide and the word width are parameters. The defaults give 800 periods per line (640 active, 16 front porch, 96 sync, 48 back porch) and 525 lines per frame (480 active, 10 front porch, 2 sync, 33 back porch).

Top module: `vga_mono_scanout`

## Requirements
- R1: Each line has H_TOTAL pixel periods, in this order: active, front porch, sync, back porch. hsync_n is 0 exactly during the sync periods.
- R2: Each frame has V_TOTAL lines, in this order: active, front porch, sync, back porch. vsync_n is 0 exactly during the sync lines.
- R3: A pixel tick occurs on every CLK_DIV-th rising clock edge after reset is released, starting with the CLK_DIV-th edge. Registered outputs change only on tick edges. Reset sets hsync_n=1, vsync_n=1, vid_en=0, pix=0, bank_sel=0, vsync_aux=0 and mem_rd=0. Tick n (counted from 0) shows line V_ACTIVE + n/H_TOTAL and pixel n mod H_TOTAL, taken modulo the frame.
- R4: vid_en is 1 exactly when both the pixel and the line lie in their active ranges.
- R5: Pixel h of active line v is bit (15 - h mod 16) of word v*(H_ACTIVE/16) + h/16, so bit 15 is shown first. A bit value of 1 gives pix=1 (white).
- R6: The last pixel of a line (h = H_ACTIVE-1) is shown while vid_en is still 1. vid_en is 0 on the next tick.
- R7: pix is 0 whenever vid_en is 0.
- R8: mem_rd is high for exactly one clock, starting at the tick edge of a fetch position. The fetch positions are: h = 16k with h < H_ACTIVE-16 on an active line, which fetches the next word of that line; and h = H_TOTAL-4 on the line before an active line, which fetches the first word of that next line. The memory returns the word on the clock edge that ends the strobe.
- R9: The first fetch of each frame uses address 0. Each later fetch in the frame uses the previous address plus one, across line boundaries.
- R10: bank_sel is cleared by reset and flips on every falling edge of vsync_n, and at no other time.
- R11: vsync_aux is always the inverse of vsync_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rdata | input | WORD_W | Word returned by the SRAM, registered on the edge that ends mem_rd |
| mem_rd | output | 1 | One-clock read strobe |
| mem_addr | output | ADDR_W | Word address, valid while mem_rd is high |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| vid_en | output | 1 | High during visible pixels |
| pix | output | 1 | Pixel value, 1 is white |
| bank_sel | output | 1 | Frame bank select, flips on each vsync start |
| vsync_aux | output | 1 | Active-high copy of vertical sync |

## Verification
A wrong phase state or position count in either sequencer moves the sync pulses and the video-enable window, and this shows on the very next tick. A fault in the fetch machine or the address counter shows one clock after the fetch tick as a missing, doubled or wrongly addressed strobe. It also shows up to sixteen ticks later as pixels taken from the wrong word. A shift register that is loaded or advanced at the wrong time changes the pixel sequence within the same line, and the last pixel of each line shows an off-by-one at the edge of the active window.

// File: rtl/vga_scan_pkg.sv
package vga_scan_pkg;

    typedef enum logic [1:0] {
        PH_ACTIVE = 2'd0,
        PH_FRONT  = 2'd1,
        PH_SYNC   = 2'd2,
        PH_BACK   = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        FT_IDLE = 2'd0,
        FT_REQ  = 2'd1,
        FT_CAPT = 2'd2
    } fetch_t;

endpackage

// File: rtl/vga_tick_gen.sv
module vga_tick_gen #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    generate
        if (DIV <= 1) begin : g_every
            assign tick = rst_n;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt;

            assign tick = (cnt == CNT_LAST);

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (tick) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/vga_axis_fsm.sv
module vga_axis_fsm
    import vga_scan_pkg::*;
#(
    parameter int ACTIVE      = 640,
    parameter int FRONT       = 16,
    parameter int SYNC        = 96,
    parameter int BACK        = 48,
    parameter int START_BLANK = 0,
    parameter int PW          = $clog2(ACTIVE + FRONT + SYNC + BACK)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [PW-1:0] pos,
    output phase_t        phase,
    output logic          last
);

    localparam int TOTAL = ACTIVE + FRONT + SYNC + BACK;
    localparam logic [PW-1:0] END_ACT   = PW'(ACTIVE - 1);
    localparam logic [PW-1:0] END_FRONT = PW'(ACTIVE + FRONT - 1);
    localparam logic [PW-1:0] END_SYNC  = PW'(ACTIVE + FRONT + SYNC - 1);
    localparam logic [PW-1:0] END_ALL   = PW'(TOTAL - 1);
    localparam logic [PW-1:0] RST_POS   = (START_BLANK != 0) ? PW'(ACTIVE) : '0;
    localparam phase_t        RST_PH    = (START_BLANK != 0) ? PH_FRONT : PH_ACTIVE;

    phase_t phase_nx;

    assign last = (pos == END_ALL);

    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_ACTIVE: if (pos == END_ACT)   phase_nx = PH_FRONT;
            PH_FRONT:  if (pos == END_FRONT) phase_nx = PH_SYNC;
            PH_SYNC:   if (pos == END_SYNC)  phase_nx = PH_BACK;
            PH_BACK:   if (pos == END_ALL)   phase_nx = PH_ACTIVE;
            default:                         phase_nx = PH_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= RST_PH;
        end else if (adv) begin
            phase <= phase_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= RST_POS;
        end else if (adv) begin
            pos <= last ? '0 : pos + 1'b1;
        end
    end

endmodule

// File: rtl/vga_word_feed.sv
module vga_word_feed
    import vga_scan_pkg::*;
#(
    parameter int H_ACTIVE = 640,
    parameter int H_TOTAL  = 800,
    parameter int V_ACTIVE = 480,
    parameter int WORD_W   = 16,
    parameter int ADDR_W   = 15,
    parameter int HW       = 10,
    parameter int VW       = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [HW-1:0]     hpos,
    input  logic [VW-1:0]     vpos,
    input  logic              h_active,
    input  logic              v_last,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              px_bit
);

    localparam int BW = $clog2(WORD_W);
    localparam logic [HW-1:0] H_FETCH_LIM = HW'(H_ACTIVE - WORD_W);
    localparam logic [HW-1:0] H_PREFETCH  = HW'(H_TOTAL - 4);
    localparam logic [HW-1:0] H_END       = HW'(H_TOTAL - 1);
    localparam logic [BW-1:0] BIT_LAST    = BW'(WORD_W - 1);
    localparam logic [VW-1:0] V_ACT       = VW'(V_ACTIVE);
    localparam logic [VW-1:0] V_ACT_LAST  = VW'(V_ACTIVE - 1);

    fetch_t              st;
    fetch_t              st_nx;
    logic [WORD_W-1:0]   word_buf;
    logic [WORD_W-1:0]   shreg;
    logic                line_act;
    logic                next_line_act;
    logic                in_act;
    logic                fetch_go;
    logic                frame_wrap;
    logic                first_load;

    assign line_act      = (vpos < V_ACT);
    assign next_line_act = v_last || (vpos < V_ACT_LAST);
    assign in_act        = line_act && h_active;
    assign fetch_go      = tick && ((in_act && (hpos[BW-1:0] == '0) && (hpos < H_FETCH_LIM))
                                 || ((hpos == H_PREFETCH) && next_line_act));
    assign frame_wrap    = tick && v_last && (hpos == '0);
    assign first_load    = (hpos == H_END) && next_line_act;
    assign px_bit        = shreg[WORD_W-1];

    always_comb begin
        st_nx = st;
        unique case (st)
            FT_IDLE: if (fetch_go) st_nx = FT_REQ;
            FT_REQ:  st_nx = FT_CAPT;
            FT_CAPT: st_nx = FT_IDLE;
            default: st_nx = FT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= FT_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_rd   <= 1'b0;
            mem_addr <= '0;
            word_buf <= '0;
        end else begin
            mem_rd <= (st_nx == FT_REQ);
            if (frame_wrap) begin
                mem_addr <= '0;
            end else if (st == FT_REQ) begin
                mem_addr <= mem_addr + 1'b1;
            end
            if (st == FT_CAPT) begin
                word_buf <= mem_rdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (tick) begin
            if (first_load) begin
                shreg <= word_buf;
            end else if (in_act) begin
                if (hpos[BW-1:0] == BIT_LAST) begin
                    shreg <= word_buf;
                end else begin
                    shreg <= {shreg[WORD_W-2:0], 1'b0};
                end
            end
        end
    end

endmodule

// File: rtl/vga_mono_scanout.sv
module vga_mono_scanout
    import vga_scan_pkg::*;
#(
    parameter int CLK_DIV  = 2,
    parameter int H_ACTIVE = 640,
    parameter int H_FRONT  = 16,
    parameter int H_SYNC   = 96,
    parameter int H_BACK   = 48,
    parameter int V_ACTIVE = 480,
    parameter int V_FRONT  = 10,
    parameter int V_SYNC   = 2,
    parameter int V_BACK   = 33,
    parameter int WORD_W   = 16,
    parameter int ADDR_W   = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              vid_en,
    output logic              pix,
    output logic              bank_sel,
    output logic              vsync_aux
);

    localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
    localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
    localparam int HW      = $clog2(H_TOTAL);
    localparam int VW      = $clog2(V_TOTAL);

    logic          tick;
    logic [HW-1:0] hpos;
    logic [VW-1:0] vpos;
    phase_t        hph;
    phase_t        vph;
    logic          hlast;
    logic          vlast;
    logic          line_adv;
    logic          h_in_act;
    logic          act;
    logic          px_bit;

    assign line_adv = tick && hlast;
    assign h_in_act = (hph == PH_ACTIVE);
    assign act      = h_in_act && (vph == PH_ACTIVE);

    vga_tick_gen #(.DIV(CLK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    vga_axis_fsm #(
        .ACTIVE(H_ACTIVE), .FRONT(H_FRONT), .SYNC(H_SYNC), .BACK(H_BACK),
        .START_BLANK(0), .PW(HW)
    ) u_hseq (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (tick),
        .pos   (hpos),
        .phase (hph),
        .last  (hlast)
    );

    vga_axis_fsm #(
        .ACTIVE(V_ACTIVE), .FRONT(V_FRONT), .SYNC(V_SYNC), .BACK(V_BACK),
        .START_BLANK(1), .PW(VW)
    ) u_vseq (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (line_adv),
        .pos   (vpos),
        .phase (vph),
        .last  (vlast)
    );

    vga_word_feed #(
        .H_ACTIVE(H_ACTIVE), .H_TOTAL(H_TOTAL), .V_ACTIVE(V_ACTIVE),
        .WORD_W(WORD_W), .ADDR_W(ADDR_W), .HW(HW), .VW(VW)
    ) u_feed (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .hpos      (hpos),
        .vpos      (vpos),
        .h_active  (h_in_act),
        .v_last    (vlast),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .px_bit    (px_bit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsync_n   <= 1'b1;
            vsync_n   <= 1'b1;
            vid_en    <= 1'b0;
            pix       <= 1'b0;
            bank_sel  <= 1'b0;
            vsync_aux <= 1'b0;
        end else if (tick) begin
            vid_en    <= act;
            pix       <= act && px_bit;
            hsync_n   <= (hph != PH_SYNC);
            vsync_n   <= (vph != PH_SYNC);
            vsync_aux <= (vph == PH_SYNC);
            if (vsync_n && (vph == PH_SYNC)) begin
                bank_sel <= ~bank_sel;
            end
        end
    end

endmodule

// File: rtl/vga_scanout_checker.sv
module vga_scanout_checker #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              hsync_n,
    input logic              vsync_n,
    input logic              vid_en,
    input logic              pix,
    input logic              bank_sel,
    input logic              vsync_aux,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr
);

    AST_AUX_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_aux == !vsync_n); // R11

    AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_en |-> !pix); // R7

    AST_SYNC_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (!hsync_n || !vsync_n) |-> !vid_en); // R4

    AST_BANK_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vsync_n) |-> (bank_sel != $past(bank_sel))); // R10

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(vsync_n) |-> $stable(bank_sel)); // R10

    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd); // R8

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (mem_addr == $past(mem_addr) + 1'b1)); // R9

    AST_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> ($stable(vid_en) && $stable(hsync_n) && $stable(vsync_n) && $stable(pix))); // R3

endmodule

bind vga_mono_scanout vga_scanout_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .hsync_n   (hsync_n),
    .vsync_n   (vsync_n),
    .vid_en    (vid_en),
    .pix       (pix),
    .bank_sel  (bank_sel),
    .vsync_aux (vsync_aux),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr)
);

// File: tb/tb_vga_mono_scanout.sv
module tb_vga_mono_scanout;

    localparam int CLK_PERIOD = 10;
    localparam int DIV = 2;
    localparam int HA = 64, HF = 4, HS = 8, HB = 8;
    localparam int VA = 4,  VF = 1, VS = 2, VB = 2;
    localparam int HT = HA + HF + HS + HB;
    localparam int VT = VA + VF + VS + VB;
    localparam int WPL = HA / 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        mem_rd;
    logic [14:0] mem_addr;
    logic        hsync_n, vsync_n, vid_en, pix, bank_sel, vsync_aux;

    logic [15:0] mem [0:63];
    int  checks = 0;
    int  errors = 0;
    bit  exp_bank;
    logic [3:0] last_outs;

    vga_mono_scanout #(
        .CLK_DIV(DIV), .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
        .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB)
    ) dut (
        .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .vid_en(vid_en), .pix(pix), .bank_sel(bank_sel), .vsync_aux(vsync_aux)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[5:0]];
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic fill_mem();
        for (int i = 0; i < 64; i++) mem[i] = 16'($urandom);
        mem[0]       = 16'h8001;
        mem[WPL-1]   = 16'h0001;
        mem[WPL]     = 16'hFFFF;
        mem[2*WPL-1] = 16'hFFFF;
        mem[2*WPL]   = 16'h0000;
        mem[3*WPL-1] = 16'h8000;
    endtask

    task automatic check_reset();
        chk("R3 reset hsync_n", hsync_n, 1);
        chk("R3 reset vsync_n", vsync_n, 1);
        chk("R3 reset vid_en", vid_en, 0);
        chk("R3 reset pix", pix, 0);
        chk("R3 reset bank_sel", bank_sel, 0);
        chk("R3 reset vsync_aux", vsync_aux, 0);
        chk("R3 reset mem_rd", mem_rd, 0);
    endtask

    task automatic check_tick(input int n);
        int q, h, v, e_pix, e_rd, e_addr;
        bit act, hs, vs;
        q = (n + VA * HT) % (HT * VT);
        h = q % HT;
        v = q / HT;
        act = (h < HA) && (v < VA);
        hs  = (h >= HA + HF) && (h < HA + HF + HS);
        vs  = (v >= VA + VF) && (v < VA + VF + VS);
        if (h == 0 && v == VA + VF) exp_bank = !exp_bank;
        e_pix = act ? int'(mem[(v * WPL + h / 16) % 64][15 - h % 16]) : 0;
        e_rd = 0;
        e_addr = 0;
        if (v < VA && h < HA - 16 && h % 16 == 0) begin
            e_rd = 1;
            e_addr = v * WPL + h / 16 + 1;
        end
        if (h == HT - 4 && (v == VT - 1 || v < VA - 1)) begin
            e_rd = 1;
            e_addr = (v == VT - 1) ? 0 : (v + 1) * WPL;
        end
        chk("R1 hsync_n", hsync_n, int'(!hs));
        chk("R2 vsync_n", vsync_n, int'(!vs));
        if (v < VA && (h == HA - 1 || h == HA)) chk("R6 vid_en edge", vid_en, int'(act));
        else chk("R4 vid_en", vid_en, int'(act));
        if (!act) chk("R7 pix blank", pix, 0);
        else if (h == HA - 1) chk("R6 last pix", pix, e_pix);
        else chk("R5 pix", pix, e_pix);
        chk("R8 mem_rd", mem_rd, e_rd);
        if (e_rd != 0) chk("R9 mem_addr", int'(mem_addr), e_addr);
        chk("R10 bank_sel", bank_sel, int'(exp_bank));
        chk("R11 vsync_aux", vsync_aux, int'(vs));
        last_outs = {hsync_n, vsync_n, vid_en, pix};
        if (h == 0 && v == VA + VF) fill_mem();
    endtask

    task automatic run_ticks(input int nticks);
        for (int k = 1; k <= nticks * DIV; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k % DIV == 0) check_tick(k / DIV - 1);
            else chk("R3 hold between ticks", int'({hsync_n, vsync_n, vid_en, pix}), int'(last_outs));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240917));
        fill_mem();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check_reset();
        last_outs = 4'b1100;
        exp_bank = 1'b0;
        rst_n = 1'b1;
        run_ticks(2 * HT * VT + 37 + int'($urandom_range(0, 200)));
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_reset();
        last_outs = 4'b1100;
        exp_bank = 1'b0;
        rst_n = 1'b1;
        run_ticks(2 * HT * VT);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule